// File: doc/BRIEF.md
# Compensated RTC Prescaler

This block is the sub-second stage of a real-time clock. A 16-bit prescaler runs on the 32.768 kHz timekeeping clock and raises a one-cycle seconds tick each time its bit 14 falls from one to zero. In a plain second this gives 32768 cycles. A signed 8-bit trim value lengthens or shortens one second in every compensation interval, so the crystal's error can be corrected in steps of one cycle.

Software writes the trim value and the interval into holding registers. They wait there and take effect only at the tick that closes the current interval. A down-counter counts the seconds in the interval. Its count and the trim value now in use can both be read back. The prescaler can be loaded only while the time counter is stopped. While the overflow or invalid flag is raised, the block is told to hold: the prescaler then reads as zero and keeps its count.

Top module: `comp_rtc_prescaler`

## Requirements
- R1: After a synchronous reset, `pre_rd`, `sec_tick`, `span_cnt` and `trim_active` are all zero, and both holding registers are zero.
- R2: The prescaler goes up by one on each clock edge where `cnt_en` is 1, `hold` is 0 and no stretch is in progress. Otherwise it keeps its value.
- R3: While `hold` is 1, `pre_rd` reads zero. The internal count is kept and shows again as soon as `hold` returns to 0.
- R4: `sec_tick` is high for exactly the one cycle that follows the edge on which prescaler bit `TICK_BIT` (14 by default) falls from 1 to 0. In that cycle, bits `TICK_BIT:0` of `pre_rd` hold the skip amount of the new second: the trim value for a positive compensation, and zero in every other case.
- R5: A prescaler write with `cnt_en` at 0 loads `pre_wdata` on the next edge. A prescaler write with `cnt_en` at 1 is ignored.
- R6: A second with no compensation lasts 2^(`TICK_BIT`+1) cycles from tick to tick (32768 by default).
- R7: A compensated second lasts 2^(`TICK_BIT`+1) minus the trim value read as two's complement. For example, 0x01 gives 32767, 0x7F gives 32641, 0xFF gives 32769 and 0x80 gives 32896. A positive trim skips prescaler states at the start of the second. A negative trim holds the prescaler still for that many cycles at the start of the second.
- R8: On each tick, `span_cnt` counts down by one if it was not zero. If it was zero, it reloads from the interval holding register and the second that starts is compensated. An interval value of N therefore compensates one second in every N+1.
- R9: Writes to the trim and interval holding registers change neither `trim_active` nor `span_cnt` until the next tick at which `span_cnt` is zero.
- R10: At that transfer tick, `trim_active` takes the held trim value. This is the value that sets the length of the second now starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock, 32.768 kHz |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Time counter running |
| hold | input | 1 | Overflow or invalid flag raised: freeze the count and read zero |
| pre_wr | input | 1 | Prescaler write strobe |
| pre_wdata | input | PRE_W | Prescaler write data |
| trim_wr | input | 1 | Trim holding register write strobe |
| trim_wdata | input | TRIM_W | Trim value, two's complement |
| span_wr | input | 1 | Interval holding register write strobe |
| span_wdata | input | SPAN_W | Interval in seconds minus one |
| sec_tick | output | 1 | One-cycle seconds tick |
| pre_rd | output | PRE_W | Prescaler read-back |
| span_cnt | output | SPAN_W | Interval down-counter |
| trim_active | output | TRIM_W | Trim value now in use |

## Verification
The effect of any error inside the block shows up as a tick that comes too early or too late. A skip amount that is wrong, or a stretch counter that is wrong, changes the length of the next second by a fixed number of cycles. That error is visible at the very next tick. A down-counter that has slipped, or a holding register transferred at the wrong time, changes which second gets compensated. That shows in `span_cnt` and `trim_active` at the tick itself, and in the length of the second that follows. For this reason the bench measures every second against a model of the interval schedule. It also checks the read-back ports at each tick.

// File: rtl/crp_pkg.sv
// Shared types for the compensated prescaler.
package crp_pkg;

    // Kind of adjustment applied at the start of a second.
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SKIP  = 2'd1,
        ADJ_STALL = 2'd2
    } adj_kind_e;

endpackage

// File: rtl/crp_divider.sv
// Prescaler counter with seconds tick and per-second trim.
// What it does: counts while running. When bit TICK_BIT falls, it flags a wrap.
// At a compensated wrap it either skips ahead by a positive trim, or it
// stalls for as many cycles as the magnitude of a negative trim.
// What it assumes: TRIM_W-1 <= TICK_BIT < PRE_W. Under that condition a skip
// never reaches bit TICK_BIT.
module crp_divider
    import crp_pkg::*;
#(
    parameter int PRE_W    = 16,
    parameter int TICK_BIT = 14,
    parameter int TRIM_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              hold,
    input  logic              pre_wr,
    input  logic [PRE_W-1:0]  pre_wdata,
    input  logic              comp_now,
    input  logic [TRIM_W-1:0] comp_val,
    output logic [PRE_W-1:0]  pre_q,
    output logic              wrap_now,
    output logic              sec_tick
);
    localparam int PAD = PRE_W - TRIM_W;

    logic              run;
    logic              step;
    logic [PRE_W-1:0]  pre_inc;
    logic [TRIM_W-1:0] stall_q;
    logic [TRIM_W-1:0] neg_mag;
    adj_kind_e         kind;

    // Decide whether this cycle counts, and whether it closes a second.
    always_comb begin
        run      = cnt_en && !hold;
        step     = run && (stall_q == '0);
        pre_inc  = pre_q + 1'b1;
        wrap_now = step && pre_q[TICK_BIT] && !pre_inc[TICK_BIT];
    end

    // Classify the trim that applies to the second now starting.
    always_comb begin
        neg_mag = -comp_val;
        if (!comp_now || comp_val == '0) begin
            kind = ADJ_NONE;
        end else if (comp_val[TRIM_W-1]) begin
            kind = ADJ_STALL;
        end else begin
            kind = ADJ_SKIP;
        end
    end

    // Prescaler, stretch counter and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            stall_q  <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= wrap_now;
            if (pre_wr && !cnt_en) begin
                pre_q   <= pre_wdata;
                stall_q <= '0;
            end else if (wrap_now) begin
                case (kind)
                    ADJ_SKIP:  pre_q <= pre_inc + {{PAD{1'b0}}, comp_val};
                    ADJ_STALL: begin
                        pre_q   <= pre_inc;
                        stall_q <= neg_mag;
                    end
                    default:   pre_q <= pre_inc;
                endcase
            end else if (step) begin
                pre_q <= pre_inc;
            end else if (run) begin
                stall_q <= stall_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/crp_trim_sched.sv
// Compensation scheduler with holding registers.
// What it does: keeps the trim and interval writes in holding registers.
// It counts seconds down on each wrap. When the count is zero at a wrap, it
// reloads the count and makes the held trim the active one.
// What it assumes: wrap_now is high for at most one cycle per second.
module crp_trim_sched #(
    parameter int TRIM_W = 8,
    parameter int SPAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trim_wr,
    input  logic [TRIM_W-1:0] trim_wdata,
    input  logic              span_wr,
    input  logic [SPAN_W-1:0] span_wdata,
    input  logic              wrap_now,
    output logic              comp_now,
    output logic [TRIM_W-1:0] comp_val,
    output logic [SPAN_W-1:0] span_cnt,
    output logic [TRIM_W-1:0] trim_active
);
    logic [TRIM_W-1:0] trim_hold;
    logic [SPAN_W-1:0] span_hold;

    // The second that starts at a zero count is compensated with the held trim.
    always_comb begin
        comp_now = (span_cnt == '0);
        comp_val = trim_hold;
    end

    // Holding registers take software writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_hold <= '0;
            span_hold <= '0;
        end else begin
            if (trim_wr) trim_hold <= trim_wdata;
            if (span_wr) span_hold <= span_wdata;
        end
    end

    // Interval down-counter and transfer into the active trim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_cnt    <= '0;
            trim_active <= '0;
        end else if (wrap_now) begin
            if (comp_now) begin
                span_cnt    <= span_hold;
                trim_active <= trim_hold;
            end else begin
                span_cnt <= span_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/comp_rtc_prescaler.sv
// Top level of the compensated RTC prescaler.
// What it does: joins the divider and the scheduler, and forces the prescaler
// read-back to zero while hold is raised.
// What it assumes: all inputs are synchronous to clk.
module comp_rtc_prescaler #(
    parameter int PRE_W    = 16,
    parameter int TICK_BIT = 14,
    parameter int TRIM_W   = 8,
    parameter int SPAN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              hold,
    input  logic              pre_wr,
    input  logic [PRE_W-1:0]  pre_wdata,
    input  logic              trim_wr,
    input  logic [TRIM_W-1:0] trim_wdata,
    input  logic              span_wr,
    input  logic [SPAN_W-1:0] span_wdata,
    output logic              sec_tick,
    output logic [PRE_W-1:0]  pre_rd,
    output logic [SPAN_W-1:0] span_cnt,
    output logic [TRIM_W-1:0] trim_active
);
    logic [PRE_W-1:0]  pre_q;
    logic              wrap_now;
    logic              comp_now;
    logic [TRIM_W-1:0] comp_val;

    crp_divider #(
        .PRE_W(PRE_W), .TICK_BIT(TICK_BIT), .TRIM_W(TRIM_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold),
        .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .comp_now(comp_now), .comp_val(comp_val),
        .pre_q(pre_q), .wrap_now(wrap_now), .sec_tick(sec_tick)
    );

    crp_trim_sched #(
        .TRIM_W(TRIM_W), .SPAN_W(SPAN_W)
    ) u_sched (
        .clk(clk), .rst_n(rst_n),
        .trim_wr(trim_wr), .trim_wdata(trim_wdata),
        .span_wr(span_wr), .span_wdata(span_wdata),
        .wrap_now(wrap_now), .comp_now(comp_now), .comp_val(comp_val),
        .span_cnt(span_cnt), .trim_active(trim_active)
    );

    // Read-back is zero while the flags hold the time counter.
    always_comb pre_rd = hold ? '0 : pre_q;

endmodule

// File: rtl/crp_checker.sv
// Temporal checks for the compensated prescaler, bound to the top level.
module crp_checker #(
    parameter int PRE_W  = 16,
    parameter int TRIM_W = 8,
    parameter int SPAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              hold,
    input logic              pre_wr,
    input logic [PRE_W-1:0]  pre_wdata,
    input logic              sec_tick,
    input logic [PRE_W-1:0]  pre_raw,
    input logic [SPAN_W-1:0] span_cnt,
    input logic [TRIM_W-1:0] trim_active
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R4
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && !cnt_en) |=> pre_raw == $past(pre_wdata)); // R5
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && cnt_en && hold) |=> $stable(pre_raw)); // R5
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !pre_wr) |=> $stable(pre_raw)); // R2
    AST_SPAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && $past(span_cnt) != '0) |-> span_cnt == $past(span_cnt) - 1'b1); // R8
    AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(span_cnt)); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(trim_active)); // R9
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pre_wr) |=> $stable(pre_raw)); // R3
endmodule

bind comp_rtc_prescaler crp_checker #(
    .PRE_W(PRE_W), .TRIM_W(TRIM_W), .SPAN_W(SPAN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold),
    .pre_wr(pre_wr), .pre_wdata(pre_wdata), .sec_tick(sec_tick),
    .pre_raw(pre_q), .span_cnt(span_cnt), .trim_active(trim_active)
);

// File: tb/sim_comp_rtc_prescaler.sv
module sim_comp_rtc_prescaler;
    localparam int PRE_W = 16;
    localparam int TB_TICK = 8;
    localparam int TRIM_W = 8;
    localparam int SPAN_W = 8;
    localparam int NOM = 1 << (TB_TICK + 1);
    localparam int LOWMASK = NOM - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_en = 1'b0;
    logic              hold = 1'b0;
    logic              pre_wr = 1'b0;
    logic [PRE_W-1:0]  pre_wdata = '0;
    logic              trim_wr = 1'b0;
    logic [TRIM_W-1:0] trim_wdata = '0;
    logic              span_wr = 1'b0;
    logic [SPAN_W-1:0] span_wdata = '0;
    logic              sec_tick;
    logic [PRE_W-1:0]  pre_rd;
    logic [SPAN_W-1:0] span_cnt;
    logic [TRIM_W-1:0] trim_active;

    int checks = 0;
    int errors = 0;

    // Reference schedule state
    int m_span = 0;
    int m_act = 0;
    int m_bspan = 0;
    int m_btrim = 0;

    always #10 clk = ~clk;

    comp_rtc_prescaler #(
        .PRE_W(PRE_W), .TICK_BIT(TB_TICK), .TRIM_W(TRIM_W), .SPAN_W(SPAN_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold),
        .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .trim_wr(trim_wr), .trim_wdata(trim_wdata),
        .span_wr(span_wr), .span_wdata(span_wdata),
        .sec_tick(sec_tick), .pre_rd(pre_rd),
        .span_cnt(span_cnt), .trim_active(trim_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sgn8(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Length of the second that starts at a tick
    function automatic int exp_len(input bit comp, input int trim);
        return comp ? NOM - sgn8(trim) : NOM;
    endfunction

    // Expected low prescaler bits just after a tick
    function automatic int exp_low(input bit comp, input int trim);
        return (comp && sgn8(trim) > 0) ? trim : 0;
    endfunction

    // Advance the reference schedule by one tick; returns compensation flag
    function automatic bit model_tick();
        if (m_span == 0) begin
            m_span = m_bspan;
            m_act = m_btrim;
            return 1'b1;
        end
        m_span = m_span - 1;
        return 1'b0;
    endfunction

    task automatic check_tick(input bit comp);
        chk(int'(span_cnt) == m_span, "R8 span_cnt at tick", int'(span_cnt), m_span);
        chk(int'(trim_active) == m_act, "R10 trim_active at tick", int'(trim_active), m_act);
        chk((int'(pre_rd) & LOWMASK) == exp_low(comp, m_act), "R4 pre_rd low bits at tick",
            int'(pre_rd) & LOWMASK, exp_low(comp, m_act));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        bit comp;
        int len;
        int c;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(pre_rd == '0, "R1 pre_rd", int'(pre_rd), 0);
        chk(sec_tick == 1'b0, "R1 sec_tick", int'(sec_tick), 0);
        chk(span_cnt == '0, "R1 span_cnt", int'(span_cnt), 0);
        chk(trim_active == '0, "R1 trim_active", int'(trim_active), 0);

        // R5 load while stopped
        pre_wr = 1'b1; pre_wdata = 16'h0020;
        @(negedge clk);
        pre_wr = 1'b0;
        chk(pre_rd == 16'h0020, "R5 load while stopped", int'(pre_rd), 32);
        repeat (3) @(negedge clk);
        chk(pre_rd == 16'h0020, "R2 frozen while stopped", int'(pre_rd), 32);

        // R2 counting
        cnt_en = 1'b1;
        repeat (5) @(negedge clk);
        chk(pre_rd == 16'h0025, "R2 counts while running", int'(pre_rd), 37);

        // R5 write ignored while running
        pre_wr = 1'b1; pre_wdata = 16'h1234;
        @(negedge clk);
        pre_wr = 1'b0;
        chk(pre_rd == 16'h0026, "R5 write ignored while running", int'(pre_rd), 38);

        // R3 hold reads zero and keeps the count
        hold = 1'b1;
        @(negedge clk);
        chk(pre_rd == '0, "R3 reads zero under hold", int'(pre_rd), 0);
        pre_wr = 1'b1; pre_wdata = 16'h0100;
        @(negedge clk);
        pre_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(pre_rd == '0, "R3 still zero under hold", int'(pre_rd), 0);
        hold = 1'b0;
        #1;
        chk(pre_rd == 16'h0026, "R3 count kept through hold", int'(pre_rd), 38);
        @(negedge clk);
        chk(pre_rd == 16'h0027, "R2 resumes after hold", int'(pre_rd), 39);

        // Restart from zero with held trim settings pending
        cnt_en = 1'b0;
        pre_wr = 1'b1; pre_wdata = '0;
        trim_wr = 1'b1; trim_wdata = 8'h05;
        span_wr = 1'b1; span_wdata = 8'd1;
        m_btrim = 5; m_bspan = 1;
        @(negedge clk);
        pre_wr = 1'b0; trim_wr = 1'b0; span_wr = 1'b0;
        chk(trim_active == '0, "R9 held trim not yet active", int'(trim_active), 0);
        chk(span_cnt == '0, "R9 held span not yet loaded", int'(span_cnt), 0);
        cnt_en = 1'b1;

        // Sync to the first tick
        c = 0;
        while (!sec_tick && c < 4 * NOM) begin
            @(negedge clk);
            c++;
        end
        chk(c == NOM, "R6 first second from zero", c, NOM);
        comp = model_tick();
        len = exp_len(comp, m_act);
        check_tick(comp);

        for (int i = 0; i < 60; i++) begin
            int nt;
            int ns;
            bit dow;
            bit lens_ok;
            if (i < 8) begin
                case (i)
                    0: nt = 8'h7F;
                    1: nt = 8'h80;
                    2: nt = 8'hFF;
                    3: nt = 8'h01;
                    4: nt = 8'h00;
                    5: nt = 8'h80;
                    6: nt = 8'h7F;
                    default: nt = 8'hFF;
                endcase
                ns = 0;
                dow = 1'b1;
            end else begin
                nt = int'($urandom_range(0, 255));
                ns = int'($urandom_range(0, 2));
                dow = ($urandom_range(0, 1) == 1);
            end
            c = 0;
            while (1) begin
                @(negedge clk);
                c++;
                if (c == 4 && dow) begin
                    trim_wr = 1'b1; trim_wdata = nt[7:0];
                    span_wr = 1'b1; span_wdata = ns[7:0];
                    m_btrim = nt; m_bspan = ns;
                end
                if (c == 5) begin
                    trim_wr = 1'b0; span_wr = 1'b0;
                end
                if (c == 8) begin
                    chk(int'(trim_active) == m_act, "R9 active trim unchanged mid-second",
                        int'(trim_active), m_act);
                    chk(int'(span_cnt) == m_span, "R9 span_cnt unchanged mid-second",
                        int'(span_cnt), m_span);
                end
                if (c == 10) begin
                    pre_wr = 1'b1; pre_wdata = 16'($urandom_range(0, 65535));
                end
                if (c == 11) pre_wr = 1'b0;
                if (sec_tick || c > 4 * NOM) break;
            end
            lens_ok = (c == len);
            if (comp) chk(lens_ok, "R7 compensated second length (R5 write ignored)", c, len);
            else      chk(lens_ok, "R6 nominal second length (R5 write ignored)", c, len);
            comp = model_tick();
            len = exp_len(comp, m_act);
            check_tick(comp);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule